// File: doc/BRIEF.md
# MDIO Management Responder

This block is the device-side end of a two-wire serial management link. A station manager drives a clock (MDC) and a shared bidirectional data line. The block samples the line on every rising clock edge and decodes each management frame. A frame that names this device's address becomes one access to a generic bank of thirty-two 16-bit registers. A read turns into a one-cycle read strobe, and the block then shifts the returned word back onto the line. A write turns into a one-cycle write strobe that carries the address and the data.

The device address is five bits wide. Its top two bits are always zero and its low three bits come from strap inputs. The block also answers address zero. Through that shared address a manager can read one device without knowing its strap, or write to every device on the line in a single frame. The data line is driven only through an output-enable, and only during the read turnaround and the read data phase.

The block runs entirely on MDC and has an asynchronous active-low reset. The register bank is external: it must return read data one clock after the read strobe and hold it there.

Top module: `mdio_slave`

## Requirements
- R1: During and right after reset, mdioOe, regRdEn and regWrEn are all low.
- R2: A frame is decoded only if at least 32 consecutive ones are seen, followed by a 0 then a 1 (the start pattern). A longer run of ones is accepted. A run of 31 or fewer ones causes the frame to be ignored.
- R3: The two opcode bits after the start pattern, first bit first, select the access: 10 is a read and 01 is a write. A frame with 00 or 11 is ignored and produces no strobe.
- R4: The five-bit device address field, MSB first, is accepted only when it equals {2'b00, strapAddr} or 5'b00000. Any other value, including a nonzero value in the top two bits, is ignored: there is no strobe and mdioOe stays low.
- R5: For an accepted read, regRdEn is high for exactly one cycle, starting just after the edge that samples the last register-address bit, with regAddr holding that five-bit field (MSB first). regRdData is sampled on the second rising edge after the edge that raised regRdEn.
- R6: In a read, mdioOe stays low for the first turnaround bit. It rises after the edge that samples that bit, with mdioOut at 0, and so drives the second turnaround bit low.
- R7: The read word is driven MSB first. Each new bit appears just after a rising edge, starting on the edge after the second turnaround bit, so the manager samples each bit on the following edge. mdioOe drops after the edge on which the manager samples bit 0.
- R8: For an accepted write, regWrEn is high for exactly one cycle, just after the edge that samples the 16th data bit, with regAddr and regWrData (the data MSB first) valid. The values on the two turnaround bits of a write are not checked.
- R9: After a frame is rejected, or after a frame completes, a fresh run of at least 32 ones is needed before the next frame is decoded.
- R10: Reads and writes to the shared address 0 behave like accesses to the device's own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock supplied by the station manager |
| rstN | input | 1 | Asynchronous active-low reset |
| strapAddr | input | 3 | Low three bits of this device's address |
| mdioIn | input | 1 | Sampled value of the management data line |
| mdioOut | output | 1 | Value driven on the data line when enabled |
| mdioOe | output | 1 | Output enable for the data line driver |
| regAddr | output | 5 | Register index for the bank access |
| regRdEn | output | 1 | One-cycle read strobe to the bank |
| regRdData | input | 16 | Read data from the bank, valid one cycle after regRdEn |
| regWrEn | output | 1 | One-cycle write strobe to the bank |
| regWrData | output | 16 | Write data to the bank |

## Verification
Counting the falling edge that drives the last register-address bit as edge k, the read strobe is due at falling edge k+1 and the driven zero at k+2. Read data bit 15-j is due at k+3+j, and the release at k+19. A write strobe is due one falling edge after the last data bit is driven. The bench drives and samples only on falling edges, counts them inside each frame task, and checks each result at exactly the edge where it falls due. A scoreboard queue receives each expected strobe when its frame ends. A monitor pops the queue on every strobe and compares kind, address and data. An empty-queue check after each frame catches both strobes that never came and strobes that should not have happened.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

  typedef enum logic [2:0] {
    sPre,
    sStart,
    sOp,
    sPhy,
    sReg,
    sTa,
    sData
  } phase_t;

  // Strobes from the frame controller to the datapath
  typedef struct packed {
    logic latchReg;  // capture register index
    logic rdFire;    // issue read strobe
    logic taDrive;   // start driving, turnaround zero
    logic loadOut;   // load read word, drive its MSB
    logic shiftOut;  // drive next read bit
    logic relOut;    // release the line
    logic wrFire;    // issue write strobe
  } strobe_t;

endpackage

// File: rtl/mdio_slave_ctrl.sv
module mdio_slave_ctrl
  import mdio_slave_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 5,
  parameter int STRAP_W = 3
) (
  input  logic               mdc,
  input  logic               rstN,
  input  logic               mdioIn,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic [DATA_W-1:0]  inShiftNext,
  output strobe_t            strb
);

  localparam int MAX_F = (DATA_W > FIELD_W) ? DATA_W : FIELD_W;
  localparam int CNT_W = $clog2(MAX_F);
  localparam int ONE_W = $clog2(PRE_LEN + 1);
  localparam int PAD_W = FIELD_W - STRAP_W;

  phase_t           state, nState;
  logic [CNT_W-1:0] bitCnt, nCnt;
  logic [ONE_W-1:0] onesCnt, nOnes;
  logic             isRead, nRead;
  logic [FIELD_W-1:0] ownAddr, phyField;

  assign ownAddr  = {{PAD_W{1'b0}}, strapAddr};
  assign phyField = inShiftNext[FIELD_W-1:0];

  always_comb begin
    nState = state;
    nCnt   = bitCnt + 1'b1;
    nOnes  = onesCnt;
    nRead  = isRead;
    strb   = '0;
    case (state)
      sPre: begin
        nCnt = '0;
        if (mdioIn) begin
          if (onesCnt != ONE_W'(PRE_LEN)) nOnes = onesCnt + 1'b1;
        end else begin
          if (onesCnt == ONE_W'(PRE_LEN)) nState = sStart;
          nOnes = '0;
        end
      end
      sStart: begin
        nCnt   = '0;
        nState = mdioIn ? sOp : sPre;
      end
      sOp: begin
        if (bitCnt == CNT_W'(1)) begin
          nCnt = '0;
          if (inShiftNext[1:0] == 2'b10) begin
            nState = sPhy;
            nRead  = 1'b1;
          end else if (inShiftNext[1:0] == 2'b01) begin
            nState = sPhy;
            nRead  = 1'b0;
          end else begin
            nState = sPre;
          end
        end
      end
      sPhy: begin
        if (bitCnt == CNT_W'(FIELD_W - 1)) begin
          nCnt   = '0;
          nState = (phyField == '0 || phyField == ownAddr) ? sReg : sPre;
        end
      end
      sReg: begin
        if (bitCnt == CNT_W'(FIELD_W - 1)) begin
          nCnt          = '0;
          nState        = sTa;
          strb.latchReg = 1'b1;
          strb.rdFire   = isRead;
        end
      end
      sTa: begin
        if (bitCnt == '0) begin
          strb.taDrive = isRead;
        end else begin
          nCnt         = '0;
          nState       = sData;
          strb.loadOut = isRead;
        end
      end
      sData: begin
        if (bitCnt == CNT_W'(DATA_W - 1)) begin
          nCnt        = '0;
          nState      = sPre;
          strb.relOut = isRead;
          strb.wrFire = !isRead;
        end else begin
          strb.shiftOut = isRead;
        end
      end
      default: nState = sPre;
    endcase
  end

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      state   <= sPre;
      bitCnt  <= '0;
      onesCnt <= '0;
      isRead  <= 1'b0;
    end else begin
      state   <= nState;
      bitCnt  <= nCnt;
      onesCnt <= nOnes;
      isRead  <= nRead;
    end
  end

  // R2
  start_after_pre_chk: assert property (@(posedge mdc) disable iff (!rstN)
    (state == sStart) |-> ($past(onesCnt) == ONE_W'(PRE_LEN)));

endmodule

// File: rtl/mdio_slave_dp.sv
module mdio_slave_dp
  import mdio_slave_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 5
) (
  input  logic               mdc,
  input  logic               rstN,
  input  logic               mdioIn,
  input  strobe_t            strb,
  input  logic [DATA_W-1:0]  regRdData,
  output logic [DATA_W-1:0]  inShiftNext,
  output logic [FIELD_W-1:0] regAddr,
  output logic               regRdEn,
  output logic               regWrEn,
  output logic [DATA_W-1:0]  regWrData,
  output logic               mdioOut,
  output logic               mdioOe
);

  logic [DATA_W-1:0] inShift;
  logic [DATA_W-2:0] outShift;

  assign inShiftNext = {inShift[DATA_W-2:0], mdioIn};

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      inShift   <= '0;
      outShift  <= '0;
      regAddr   <= '0;
      regRdEn   <= 1'b0;
      regWrEn   <= 1'b0;
      regWrData <= '0;
      mdioOut   <= 1'b0;
      mdioOe    <= 1'b0;
    end else begin
      inShift <= inShiftNext;
      regRdEn <= strb.rdFire;
      regWrEn <= strb.wrFire;
      if (strb.latchReg) regAddr <= inShiftNext[FIELD_W-1:0];
      if (strb.wrFire) regWrData <= inShiftNext;
      if (strb.taDrive) begin
        mdioOe  <= 1'b1;
        mdioOut <= 1'b0;
      end else if (strb.loadOut) begin
        mdioOut  <= regRdData[DATA_W-1];
        outShift <= regRdData[DATA_W-2:0];
      end else if (strb.shiftOut) begin
        mdioOut  <= outShift[DATA_W-2];
        outShift <= {outShift[DATA_W-3:0], 1'b0};
      end else if (strb.relOut) begin
        mdioOe  <= 1'b0;
        mdioOut <= 1'b0;
      end
    end
  end

  // R5
  rd_pulse_chk: assert property (@(posedge mdc) disable iff (!rstN)
    regRdEn |=> !regRdEn);

  // R8
  wr_pulse_chk: assert property (@(posedge mdc) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R6
  ta_zero_chk: assert property (@(posedge mdc) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);

  // R6
  ta_after_rd_chk: assert property (@(posedge mdc) disable iff (!rstN)
    $rose(mdioOe) |-> $past(regRdEn));

  // R5
  rd_wr_excl_chk: assert property (@(posedge mdc) disable iff (!rstN)
    !(regRdEn && regWrEn));

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
  import mdio_slave_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 5,
  parameter int STRAP_W = 3
) (
  input  logic               mdc,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic               mdioIn,
  output logic               mdioOut,
  output logic               mdioOe,
  output logic [FIELD_W-1:0] regAddr,
  output logic               regRdEn,
  input  logic [DATA_W-1:0]  regRdData,
  output logic               regWrEn,
  output logic [DATA_W-1:0]  regWrData
);

  strobe_t           strb;
  logic [DATA_W-1:0] inShiftNext;

  mdio_slave_ctrl #(
    .PRE_LEN(PRE_LEN), .DATA_W(DATA_W), .FIELD_W(FIELD_W), .STRAP_W(STRAP_W)
  ) uCtrl (
    .mdc(mdc), .rstN(rstN), .mdioIn(mdioIn), .strapAddr(strapAddr),
    .inShiftNext(inShiftNext), .strb(strb)
  );

  mdio_slave_dp #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W)
  ) uDp (
    .mdc(mdc), .rstN(rstN), .mdioIn(mdioIn), .strb(strb),
    .regRdData(regRdData), .inShiftNext(inShiftNext), .regAddr(regAddr),
    .regRdEn(regRdEn), .regWrEn(regWrEn), .regWrData(regWrData),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

endmodule

// File: tb/tb_mdio_slave.sv
module tb_mdio_slave;

  localparam int PER = 20;

  logic        mdc = 1'b0;
  logic        rstN = 1'b0;
  logic        mdioIn = 1'b1;
  logic [2:0]  strapAddr = 3'd5;
  logic        mdioOut, mdioOe, regRdEn, regWrEn;
  logic [4:0]  regAddr;
  logic [15:0] regRdData, regWrData;

  always #(PER/2) mdc = ~mdc;

  mdio_slave dut (
    .mdc(mdc), .rstN(rstN), .strapAddr(strapAddr), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .regAddr(regAddr), .regRdEn(regRdEn),
    .regRdData(regRdData), .regWrEn(regWrEn), .regWrData(regWrData)
  );

  function automatic logic [15:0] initVal(int i);
    return 16'hC3A5 ^ (16'(i) * 16'h0101);
  endfunction

  // Register bank: read data registered one cycle after the strobe
  logic [15:0] bank [32];
  always @(posedge mdc) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) bank[i] <= initVal(i);
      regRdData <= '0;
    end else begin
      if (regWrEn) bank[regAddr] <= regWrData;
      if (regRdEn) regRdData <= bank[regAddr];
    end
  end

  logic [15:0] model [32];

  typedef struct {
    bit          isWr;
    logic [4:0]  a;
    logic [15:0] d;
  } item_t;
  item_t expQ[$];

  int nChk = 0;
  int nFail = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every strobe
  item_t e;
  always @(negedge mdc) begin
    if (rstN && (regRdEn || regWrEn)) begin
      if (expQ.size() == 0) begin
        chk("R4", "unexpected strobe", 32'(1), 32'(0));
      end else begin
        e = expQ.pop_front();
        chk(e.isWr ? "R8" : "R5", "strobe kind", 32'(regWrEn), 32'(e.isWr));
        chk(e.isWr ? "R8" : "R5", "strobe addr", 32'(regAddr), 32'(e.a));
        if (e.isWr) chk("R8", "write data", 32'(regWrData), 32'(e.d));
      end
    end
  end

  task automatic bitOut(logic b);
    @(negedge mdc);
    mdioIn = b;
  endtask

  task automatic hdr(logic [1:0] op, logic [4:0] phy, logic [4:0] ra);
    bitOut(1'b0);
    bitOut(1'b1);
    for (int i = 1; i >= 0; i--) bitOut(op[i]);
    for (int i = 4; i >= 0; i--) bitOut(phy[i]);
    for (int i = 4; i >= 0; i--) bitOut(ra[i]);
  endtask

  task automatic idleChk(string req);
    repeat (3) bitOut(1'b1);
    chk(req, "pending strobes", 32'(expQ.size()), 32'(0));
  endtask

  task automatic doWrite(int preLen, logic [4:0] phy, logic [4:0] ra, logic [15:0] d,
                         bit accept, logic [1:0] ta, string req);
    repeat (preLen) bitOut(1'b1);
    hdr(2'b01, phy, ra);
    bitOut(ta[1]);
    bitOut(ta[0]);
    for (int i = 15; i >= 0; i--) bitOut(d[i]);
    if (accept) begin
      expQ.push_back('{1'b1, ra, d});
      model[ra] = d;
    end
    bitOut(1'b1);
    chk(req, "write strobe due", 32'(regWrEn), 32'(accept));
    idleChk(req);
  endtask

  task automatic doRead(logic [4:0] phy, logic [4:0] ra, bit accept, string req);
    logic [15:0] got;
    bit oeOk;
    repeat (32) bitOut(1'b1);
    hdr(2'b10, phy, ra);
    if (accept) expQ.push_back('{1'b0, ra, 16'h0});
    bitOut(1'b1);
    chk("R5", "read strobe due", 32'(regRdEn), 32'(accept));
    chk("R6", "oe in first turnaround bit", 32'(mdioOe), 32'(0));
    bitOut(1'b1);
    chk("R6", "oe/out in second turnaround bit", 32'({mdioOe, mdioOut}),
        32'(accept ? 2'b10 : 2'b00));
    oeOk = 1'b1;
    for (int j = 0; j < 16; j++) begin
      bitOut(1'b1);
      got[15-j] = mdioOut;
      if (mdioOe !== accept) oeOk = 1'b0;
    end
    chk(accept ? "R7" : "R4", "oe during data", 32'(oeOk), 32'(1));
    bitOut(1'b1);
    chk("R7", "oe released after data", 32'(mdioOe), 32'(0));
    if (accept) chk(req, "read word", 32'(got), 32'(model[ra]));
    idleChk(req);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = initVal(i);
    repeat (3) @(negedge mdc);
    // R1 reset state
    chk("R1", "mdioOe in reset", 32'(mdioOe), 32'(0));
    chk("R1", "regRdEn in reset", 32'(regRdEn), 32'(0));
    chk("R1", "regWrEn in reset", 32'(regWrEn), 32'(0));
    rstN = 1'b1;
    @(negedge mdc);
    chk("R1", "idle after reset", 32'({mdioOe, regRdEn, regWrEn}), 32'(0));

    // R8 write then R7 read at own address
    doWrite(32, 5'd5, 5'd3, 16'hBEEF, 1'b1, 2'b10, "R8");
    doRead(5'd5, 5'd3, 1'b1, "R7");
    // R5 lowest register, reset content
    doRead(5'd5, 5'd0, 1'b1, "R5");

    // R10 shared address, highest register
    doWrite(32, 5'd0, 5'd31, 16'h8001, 1'b1, 2'b10, "R10");
    doRead(5'd0, 5'd31, 1'b1, "R10");
    doRead(5'd0, 5'd3, 1'b1, "R10");

    // R4 foreign addresses ignored
    doWrite(32, 5'd6, 5'd3, 16'h1234, 1'b0, 2'b10, "R4");
    doWrite(32, 5'h0D, 5'd3, 16'h5678, 1'b0, 2'b10, "R4");
    doRead(5'd7, 5'd3, 1'b0, "R4");
    doRead(5'd5, 5'd3, 1'b1, "R4");

    // R3 bad opcodes 11 and 00 ignored
    for (int k = 0; k < 2; k++) begin
      repeat (32) bitOut(1'b1);
      hdr((k == 0) ? 2'b11 : 2'b00, 5'd5, 5'd4);
      bitOut(1'b1); bitOut(1'b0);
      for (int i = 15; i >= 0; i--) bitOut(i[0]);
      idleChk("R3");
    end
    doRead(5'd5, 5'd4, 1'b1, "R3");

    // R2 preamble of 31 ones is too short
    bitOut(1'b0); bitOut(1'b0);
    doWrite(31, 5'd5, 5'd6, 16'h0F0F, 1'b0, 2'b10, "R2");
    doRead(5'd5, 5'd6, 1'b1, "R2");
    // R2 longer preamble accepted
    doWrite(40, 5'd5, 5'd6, 16'h7E81, 1'b1, 2'b10, "R2");
    doRead(5'd5, 5'd6, 1'b1, "R2");

    // R9 rejected frame followed by a frame without a new preamble
    repeat (32) bitOut(1'b1);
    bitOut(1'b0); bitOut(1'b1); bitOut(1'b1); bitOut(1'b1);
    hdr(2'b01, 5'd5, 5'd9);
    bitOut(1'b1); bitOut(1'b0);
    for (int i = 15; i >= 0; i--) bitOut(i[1]);
    idleChk("R9");
    doRead(5'd5, 5'd9, 1'b1, "R9");

    // R8 write turnaround bits are not checked
    doWrite(32, 5'd5, 5'd12, 16'hA55A, 1'b1, 2'b00, "R8");
    doRead(5'd5, 5'd12, 1'b1, "R8");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge mdc);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule